// File: doc/BRIEF.md
# Lockstep SIMD Processing Element

This block is one 16-bit lane of a SIMD array. Many copies sit beside each other, and one shared controller drives all of them. Every cycle the controller sends the same instruction to every lane. The instruction carries an opcode, three register indices, an immediate value and a broadcast operand. Each lane runs the instruction on its own 16-entry register file with an add/subtract and logic unit. The result is held in a register and written into the register file one cycle later. A forwarding path makes that result visible to the very next instruction.

Each lane keeps a one-bit activity flag. The controller can set this flag in every lane from that lane's zero or sign flag, and it can force the flag back to one in all lanes. A lane whose flag is clear still takes one cycle per instruction, so the array stays in lockstep. It does not change its registers, its condition flags or its activity state, except when it is forced back to one. A lane shows one of its registers on its result output while its select input is high. Otherwise the output is all zeros, so the array's result bus is the OR of all lane outputs.

Top module: `simd_pe`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears every register to 0 and clears the zero and sign flags to 0. It sets the activity flag to 1.
- R2: Opcode encodings, with A = register `ra` and B = the selected operand. 1 ADD gives A+B, 2 SUB gives A-B, 3 AND, 4 OR, 5 XOR, 6 MOV gives B. All results are modulo 2^16 and are written to register `rd`. Opcodes 0 and 11 to 15 do nothing.
- R3: `src` picks operand B. 0 is register `rb`, 1 is `imm`, 2 is `bcast`, 3 is the constant 0.
- R4: An ALU result is captured in a register at the issue edge and written into the register file at the next edge. An instruction issued in the following cycle, and the result output in that cycle, see the new value through forwarding.
- R5: Every ALU opcode (1 to 6) executed while active sets the zero flag to (result==0) and the sign flag to result bit 15.
- R6: Opcodes that set the activity flag while active: 7 sets it to the zero flag, 8 sets it to the inverse of the zero flag, 9 sets it to the sign flag. The new value applies from the next instruction.
- R7: While the activity flag is 0, ALU opcodes write no register and leave both flags unchanged, and opcodes 7 to 9 leave the activity flag at 0. Opcode 10 sets the activity flag to 1 in every lane, whatever its state.
- R8: While `sel` is 1, `bus_out` shows register `ra` (forwarded as in R4). While `sel` is 0, `bus_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 4 | Broadcast opcode |
| rd | input | 4 | Destination register index |
| ra | input | 4 | First operand index, also the result-output index |
| rb | input | 4 | Second operand register index |
| src | input | 2 | Operand B source select |
| imm | input | 16 | Broadcast immediate |
| bcast | input | 16 | Broadcast bus operand |
| sel | input | 1 | Drive result output |
| bus_out | output | 16 | Result bus contribution, zero when not selected |
| active | output | 1 | Current activity flag |

## Verification
The bench issues back-to-back instructions where the next instruction reads the register that was just written. A lane without forwarding would return the old value there. The bench runs long stretches with the lane inactive, mixing ALU opcodes and opcodes 7 to 9. A design that lets writes, flag updates or conditional sets through in that state would drift from the model, and a design that ignores opcode 10 would stay stuck inactive. Every cycle it also checks that a lane that is not selected drives all zeros, which an OR-combined bus depends on. It checks every operand source against zero, negative and wrap-around results as well.

// File: rtl/simd_pe.sv
module simd_pe #(
  parameter int DW   = 16,
  parameter int NREG = 16,
  parameter int OPW  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [OPW-1:0]          op,
  input  logic [$clog2(NREG)-1:0] rd,
  input  logic [$clog2(NREG)-1:0] ra,
  input  logic [$clog2(NREG)-1:0] rb,
  input  logic [1:0]              src,
  input  logic [DW-1:0]           imm,
  input  logic [DW-1:0]           bcast,
  input  logic                    sel,
  output logic [DW-1:0]           bus_out,
  output logic                    active
);
  localparam int AW = $clog2(NREG);
  localparam logic [OPW-1:0] OP_ADD  = OPW'(1);
  localparam logic [OPW-1:0] OP_SUB  = OPW'(2);
  localparam logic [OPW-1:0] OP_AND  = OPW'(3);
  localparam logic [OPW-1:0] OP_OR   = OPW'(4);
  localparam logic [OPW-1:0] OP_XOR  = OPW'(5);
  localparam logic [OPW-1:0] OP_MOV  = OPW'(6);
  localparam logic [OPW-1:0] OP_AZ   = OPW'(7);
  localparam logic [OPW-1:0] OP_ANZ  = OPW'(8);
  localparam logic [OPW-1:0] OP_ANEG = OPW'(9);
  localparam logic [OPW-1:0] OP_AALL = OPW'(10);

  logic [DW-1:0] rf [NREG];
  logic          wr_q;
  logic [AW-1:0] wi_q;
  logic [DW-1:0] res_q;
  logic          zf, nf, act;
  logic [DW-1:0] opa, opr, opb, alu;
  logic          is_alu, do_wr;

  function automatic logic [DW-1:0] rd_port(input logic [AW-1:0] idx);
    return (wr_q && wi_q == idx) ? res_q : rf[idx];
  endfunction

  assign opa = rd_port(ra);
  assign opr = rd_port(rb);

  always_comb begin
    case (src)
      2'd0:    opb = opr;
      2'd1:    opb = imm;
      2'd2:    opb = bcast;
      default: opb = '0;
    endcase
  end

  always_comb begin
    is_alu = 1'b1;
    case (op)
      OP_ADD:  alu = opa + opb;
      OP_SUB:  alu = opa - opb;
      OP_AND:  alu = opa & opb;
      OP_OR:   alu = opa | opb;
      OP_XOR:  alu = opa ^ opb;
      OP_MOV:  alu = opb;
      default: begin alu = '0; is_alu = 1'b0; end
    endcase
  end

  assign do_wr = act && is_alu;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= 1'b0;
      wi_q  <= '0;
      res_q <= '0;
      zf    <= 1'b0;
      nf    <= 1'b0;
      act   <= 1'b1;
    end else begin
      wr_q <= do_wr;
      if (do_wr) begin
        wi_q  <= rd;
        res_q <= alu;
        zf    <= (alu == '0);
        nf    <= alu[DW-1];
      end
      if (op == OP_AALL) act <= 1'b1;
      else if (act) begin
        case (op)
          OP_AZ:   act <= zf;
          OP_ANZ:  act <= !zf;
          OP_ANEG: act <= nf;
          default: act <= act;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (wr_q) begin
      rf[wi_q] <= res_q;
    end
  end

  assign bus_out = sel ? opa : '0;
  assign active  = act;
endmodule

module simd_pe_chk #(
  parameter int DW  = 16,
  parameter int OPW = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [OPW-1:0] op,
  input logic           sel,
  input logic [DW-1:0]  bus_out,
  input logic           active,
  input logic           zf,
  input logic           nf,
  input logic           wr_q
);
  localparam logic [OPW-1:0] C_AALL = OPW'(10);

  AST_RESET_ACTIVE: assert property (@(posedge clk) rst |=> active); // R1
  AST_RESET_FLAGS: assert property (@(posedge clk) rst |=> (!zf && !nf && !wr_q)); // R1
  AST_BUS_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst) !sel |-> bus_out == '0); // R8
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst) (!active && !$past(rst)) |=> !wr_q); // R7
  AST_FLAGS_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !active |=> ($stable(zf) && $stable(nf))); // R7
  AST_IDLE_STICKY: assert property (@(posedge clk) disable iff (rst) (!active && op != C_AALL) |=> !active); // R7
  AST_RESTORE_ALL: assert property (@(posedge clk) disable iff (rst) op == C_AALL |=> active); // R7
endmodule

bind simd_pe simd_pe_chk #(.DW(DW), .OPW(OPW)) u_chk (
  .clk(clk), .rst(rst), .op(op), .sel(sel), .bus_out(bus_out),
  .active(active), .zf(zf), .nf(nf), .wr_q(wr_q)
);

// File: tb/test_simd_pe.sv
module test_simd_pe;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic clk = 0, rst = 1;
  logic [3:0] op = 0, rd = 0, ra = 0, rb = 0;
  logic [1:0] src = 0;
  logic [DW-1:0] imm = 0, bcast = 0;
  logic sel = 0;
  logic [DW-1:0] bus_out;
  logic active;

  int checks = 0, failures = 0;
  logic [DW-1:0] m_rf [16];
  logic m_z, m_n, m_act;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_pe i_simd_pe (.clk(clk), .rst(rst), .op(op), .rd(rd), .ra(ra), .rb(rb),
    .src(src), .imm(imm), .bcast(bcast), .sel(sel), .bus_out(bus_out), .active(active));

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] m_opb(input logic [1:0] s, input logic [3:0] b,
                                          input logic [DW-1:0] im, input logic [DW-1:0] bc);
    case (s)
      2'd0: return m_rf[b];
      2'd1: return im;
      2'd2: return bc;
      default: return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] m_alu(input logic [3:0] o, input logic [DW-1:0] a,
                                          input logic [DW-1:0] b);
    case (o)
      4'd1: return a + b;
      4'd2: return a - b;
      4'd3: return a & b;
      4'd4: return a | b;
      4'd5: return a ^ b;
      default: return b;
    endcase
  endfunction

  // Drive at negedge, check combinational outputs, then apply the edge to the model.
  task automatic step(input string req, input logic [3:0] o, input logic [3:0] d,
                      input logic [3:0] a, input logic [3:0] b, input logic [1:0] s,
                      input logic [DW-1:0] im, input logic [DW-1:0] bc, input logic sl);
    logic [DW-1:0] r;
    @(negedge clk);
    op = o; rd = d; ra = a; rb = b; src = s; imm = im; bcast = bc; sel = sl;
    #1;
    check({req, " R8 bus"}, bus_out, sl ? m_rf[a] : '0);
    check({req, " active"}, {15'd0, active}, {15'd0, m_act});
    @(posedge clk);
    if (o >= 4'd1 && o <= 4'd6 && m_act) begin
      r = m_alu(o, m_rf[a], m_opb(s, b, im, bc));
      m_rf[d] = r; m_z = (r == 0); m_n = r[DW-1];
    end else if (o == 4'd10) m_act = 1'b1;
    else if (m_act && o == 4'd7) m_act = m_z;
    else if (m_act && o == 4'd8) m_act = !m_z;
    else if (m_act && o == 4'd9) m_act = m_n;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) m_rf[i] = '0;
    m_z = 0; m_n = 0; m_act = 1;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: reset state seen through the bus
    for (int i = 0; i < 16; i++) step("R1", 4'd0, 4'd0, 4'(i), 4'd0, 2'd0, 0, 0, 1'b1);
    // R3: each operand source, R4: back-to-back forwarding
    step("R3 imm", 4'd6, 4'd1, 4'd0, 4'd0, 2'd1, 16'h1234, 0, 1'b0);
    step("R4 fwd", 4'd1, 4'd2, 4'd1, 4'd0, 2'd2, 0, 16'h0101, 1'b1);
    step("R4 fwd", 4'd2, 4'd3, 4'd2, 4'd1, 2'd0, 0, 0, 1'b1);
    step("R3 zero", 4'd1, 4'd4, 4'd3, 4'd0, 2'd3, 16'hffff, 16'hffff, 1'b1);
    step("R2 read", 4'd0, 4'd0, 4'd3, 4'd0, 2'd0, 0, 0, 1'b1);
    // R2/R5: wrap to zero, then R6 set active from zero flag
    step("R2 wrap", 4'd1, 4'd5, 4'd1, 4'd0, 2'd1, 16'hedcc, 0, 1'b0);
    step("R6 az", 4'd7, 4'd0, 4'd5, 4'd0, 2'd0, 0, 0, 1'b1);
    step("R2 neg", 4'd2, 4'd6, 4'd5, 4'd0, 2'd1, 16'd1, 0, 1'b1);
    step("R6 anz", 4'd8, 4'd0, 4'd6, 4'd0, 2'd0, 0, 0, 1'b1);
    step("R6 aneg", 4'd9, 4'd0, 4'd6, 4'd0, 2'd0, 0, 0, 1'b1);
    // R7: make inactive via zero flag clear, then try writes and sets
    step("R5 z0", 4'd6, 4'd7, 4'd0, 4'd0, 2'd1, 16'h0005, 0, 1'b1);
    step("R7 go idle", 4'd7, 4'd0, 4'd7, 4'd0, 2'd0, 0, 0, 1'b1);
    step("R7 blocked", 4'd6, 4'd7, 4'd0, 4'd0, 2'd3, 0, 0, 1'b1);
    step("R7 blocked", 4'd8, 4'd0, 4'd7, 4'd0, 2'd0, 0, 0, 1'b1);
    step("R7 hold", 4'd0, 4'd0, 4'd7, 4'd0, 2'd0, 0, 0, 1'b1);
    step("R7 restore", 4'd10, 4'd0, 4'd7, 4'd0, 2'd0, 0, 0, 1'b1);
    step("R7 after", 4'd0, 4'd0, 4'd7, 4'd0, 2'd0, 0, 0, 1'b0);
    // Random mix
    for (int n = 0; n < 4000; n++) begin
      int k;
      logic [3:0] o;
      logic [DW-1:0] im;
      k = $urandom_range(0, 19);
      o = (k < 12) ? 4'($urandom_range(1, 6)) : (k < 17) ? 4'($urandom_range(7, 9)) :
          (k < 18) ? 4'd10 : 4'($urandom_range(11, 15));
      im = ($urandom_range(0, 3) == 0) ? 16'h0000 : 16'($urandom);
      step("R2 R5 R6 R7 rand", o, 4'($urandom), 4'($urandom), 4'($urandom),
           2'($urandom), im, 16'($urandom), 1'($urandom));
    end
    for (int i = 0; i < 16; i++) step("R4 final", 4'd0, 4'd0, 4'(i), 4'd0, 2'd0, 0, 0, 1'b1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule